// File: doc/BRIEF.md
# Read-Data Parity Machine-Check Capture

This block sits beside a processor's external bus interface and watches read transfers. Every data beat returned on a read is checked lane by lane for even parity. A bad beat raises a one-cycle parity-check pulse. The block then decides whether the system's parity-enable input counts for that beat. That depends on the kind of cycle, the processor's operating state, the arbitration and reset lines, and whether the cycle began before address-hold was raised.

When an error occurs and the enable input counts, the block stores the failing cycle's physical address and a cycle-type word in two 64-bit capture registers. It can also request a machine-check exception with vector 0x12, but only when the machine-check enable bit is set. A bus-check input can request the same exception through the same path.

Software reads the capture registers through a small read port. Any read clears the valid flag, and the registers can only be overwritten again once that flag is clear.

Top module: `rdpar_mc_capture`

## Requirements
- R1: Data parity is even per 8-bit lane: lane k is faulty when the XOR of data bits [8k+7:8k] and parity bit k is 1. On a data-ready beat of an active read cycle with any faulty lane, `par_err_o` is high for exactly the cycle after that beat. Otherwise it stays low.
- R2: A logged error writes the address register with the cycle's address, zero-extended. It writes the type register with bit0 valid=1, bit1 write, bit2 data/code, bit3 memory/IO, bit4 lock, and the faulty-lane mask starting at bit 8, with all other bits 0.
- R3: When `par_en_i` is low at the faulty beat, nothing is logged and no exception is requested, but `par_err_o` still pulses.
- R4: Write cycles, which include special cycles, are never parity-checked or logged.
- R5: `cpu_state_i` encodes 0 normal, 1 system-management, 2 shutdown, 3 halt, 4 stop-grant, 5 stop-clock, and 6 or 7 reserved. Parity-enable counts in states 0 and 1 in every case. In any other state it counts only while `probe_rdy_i` is high.
- R6: While `backoff_i`, `hold_ack_i` or `init_i` is high at a beat, parity-enable is ignored, even with `probe_rdy_i` high.
- R7: A cycle whose address strobe came while `addr_hold_i` was high is never logged. A cycle that started before address-hold is still logged at a later beat taken while address-hold is high.
- R8: `mc_req_o` is high in the cycle after a logged error only when `mce_i` was high at that beat. `mc_vector_o` reads 0x12 while `mc_req_o` is high and 0 otherwise.
- R9: `bus_err_i` with `mce_i` high raises `mc_req_o` in the next cycle and does not touch the capture registers. With `mce_i` low it has no effect.
- R10: While the valid flag is set, later logged errors leave both registers unchanged. Any read clears the flag, and the next logged error then overwrites both registers.
- R11: With `rd_en_i` high, `rd_data_o` shows the address register (`rd_sel_i`=0) or the type register (`rd_sel_i`=1) in the next cycle, holding its value from before that read's clearing.
- R12: A cycle strobed with `burst_i` high takes BEATS data-ready beats, and each beat is checked. Data-ready beats after the last one, or with no cycle open, are ignored.
- R13: After reset, `par_err_o` and `mc_req_o` are low and both capture registers read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_strobe_i | input | 1 | Opens a bus cycle and latches its address and type |
| addr_i | input | ADDR_W | Physical address of the cycle |
| cyc_mem_i | input | 1 | 1 memory, 0 I/O |
| cyc_data_i | input | 1 | 1 data, 0 code or interrupt acknowledge |
| cyc_write_i | input | 1 | 1 write or special cycle, 0 read |
| cyc_lock_i | input | 1 | Locked cycle |
| burst_i | input | 1 | Cycle takes BEATS beats |
| data_rdy_i | input | 1 | Data beat strobe |
| data_i | input | DATA_W | Read data |
| data_par_i | input | DATA_W/8 | Even parity per byte lane |
| par_en_i | input | 1 | System parity-enable |
| cpu_state_i | input | 3 | Operating state code (R5) |
| probe_rdy_i | input | 1 | Probe-ready active |
| backoff_i | input | 1 | Bus backoff |
| hold_ack_i | input | 1 | Hold acknowledge |
| init_i | input | 1 | Processor init |
| addr_hold_i | input | 1 | Address hold |
| mce_i | input | 1 | Machine-check enable control bit |
| bus_err_i | input | 1 | Bus-check error |
| rd_en_i | input | 1 | Capture read strobe |
| rd_sel_i | input | 1 | 0 address register, 1 type register |
| par_err_o | output | 1 | Parity-check pulse |
| mc_req_o | output | 1 | Machine-check exception request |
| mc_vector_o | output | 8 | Exception vector |
| rd_data_o | output | 64 | Read port data |

## Verification
The pulses `par_err_o`, `mc_req_o` and `mc_vector_o` come from one register stage, so they are due in the cycle right after the beat or bus-check that caused them. The capture registers are written at that same edge. A read result appears one cycle after `rd_en_i`. The bench drives every input on a falling edge and holds a beat for one cycle. It samples the pulses at the next falling edge, which falls inside the single cycle when they are valid. It inspects the capture registers only through the read port, reading the type register before the address register so that the valid flag is still visible.

// File: rtl/rpm_pkg.sv
package rpm_pkg;

   typedef enum logic [2:0] {
      ST_NORMAL    = 3'd0,
      ST_SMM       = 3'd1,
      ST_SHUTDOWN  = 3'd2,
      ST_HALT      = 3'd3,
      ST_STOPGRANT = 3'd4,
      ST_STOPCLK   = 3'd5
   } cpu_state_e;

   typedef struct packed {
      logic lock;
      logic mem;
      logic data;
      logic write;
   } cyc_kind_t;

   localparam int unsigned TYP_VALID    = 0;
   localparam int unsigned TYP_WR       = 1;
   localparam int unsigned TYP_DC       = 2;
   localparam int unsigned TYP_MIO      = 3;
   localparam int unsigned TYP_LOCK     = 4;
   localparam int unsigned TYP_LANE_LSB = 8;
   localparam int unsigned CAP_W        = 64;
   localparam logic [7:0]  MC_VECTOR    = 8'h12;

   function automatic logic state_samples(input logic [2:0] st);
      return (st == 3'(ST_NORMAL)) || (st == 3'(ST_SMM));
   endfunction

endpackage

// File: rtl/rpm_lane_parity.sv
module rpm_lane_parity #(
   parameter int unsigned DATA_W = 64,
   localparam int unsigned LANES = DATA_W / 8
) (
   input  logic [DATA_W-1:0] data_i,
   input  logic [LANES-1:0]  par_i,
   output logic [LANES-1:0]  lane_err_o
);

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      assign lane_err_o[g] = ^{data_i[g*8 +: 8], par_i[g]};
   end

endmodule

// File: rtl/rpm_cycle_track.sv
module rpm_cycle_track
   import rpm_pkg::*;
#(
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned BEATS  = 4
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              strobe_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  cyc_kind_t         kind_i,
   input  logic              burst_i,
   input  logic              addr_hold_i,
   input  logic              data_rdy_i,
   output logic              active_o,
   output logic              elig_o,
   output logic [ADDR_W-1:0] addr_o,
   output cyc_kind_t         kind_o
);

   logic last_beat;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         addr_o <= '0;
         kind_o <= '0;
         elig_o <= 1'b0;
      end else if (strobe_i) begin
         addr_o <= addr_i;
         kind_o <= kind_i;
         elig_o <= !addr_hold_i;
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         active_o <= 1'b0;
      end else if (strobe_i) begin
         active_o <= 1'b1;
      end else if (data_rdy_i && active_o && last_beat) begin
         active_o <= 1'b0;
      end
   end

   if (BEATS > 1) begin : g_burst
      localparam int unsigned CNT_W = $clog2(BEATS);
      logic [CNT_W-1:0] cnt_q;
      logic             burst_q;

      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            cnt_q   <= '0;
            burst_q <= 1'b0;
         end else if (strobe_i) begin
            cnt_q   <= '0;
            burst_q <= burst_i;
         end else if (data_rdy_i && active_o) begin
            cnt_q <= cnt_q + 1'b1;
         end
      end

      assign last_beat = !burst_q || (cnt_q == CNT_W'(BEATS - 1));
   end else begin : g_single
      assign last_beat = 1'b1;
   end

endmodule

// File: rtl/rpm_capture.sv
module rpm_capture
   import rpm_pkg::*;
#(
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned LANES  = 8
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              log_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  cyc_kind_t         kind_i,
   input  logic [LANES-1:0]  lanes_i,
   input  logic              rd_en_i,
   input  logic              rd_sel_i,
   output logic [CAP_W-1:0]  rd_data_o,
   output logic              valid_o,
   output logic [CAP_W-1:0]  addr_q_o
);

   logic [CAP_W-1:0] type_q;
   logic [CAP_W-1:0] type_new;

   always_comb begin
      type_new                          = '0;
      type_new[TYP_VALID]               = 1'b1;
      type_new[TYP_WR]                  = kind_i.write;
      type_new[TYP_DC]                  = kind_i.data;
      type_new[TYP_MIO]                 = kind_i.mem;
      type_new[TYP_LOCK]                = kind_i.lock;
      type_new[TYP_LANE_LSB +: LANES]   = lanes_i;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         addr_q_o  <= '0;
         type_q    <= '0;
         rd_data_o <= '0;
      end else begin
         if (rd_en_i) begin
            rd_data_o         <= rd_sel_i ? type_q : addr_q_o;
            type_q[TYP_VALID] <= 1'b0;
         end
         if (log_i && !type_q[TYP_VALID]) begin
            addr_q_o <= CAP_W'(addr_i);
            type_q   <= type_new;
         end
      end
   end

   assign valid_o = type_q[TYP_VALID];

endmodule

// File: rtl/rdpar_mc_capture.sv
module rdpar_mc_capture
   import rpm_pkg::*;
#(
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned DATA_W = 64,
   parameter int unsigned BEATS  = 4,
   localparam int unsigned LANES = DATA_W / 8
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              addr_strobe_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              cyc_mem_i,
   input  logic              cyc_data_i,
   input  logic              cyc_write_i,
   input  logic              cyc_lock_i,
   input  logic              burst_i,
   input  logic              data_rdy_i,
   input  logic [DATA_W-1:0] data_i,
   input  logic [LANES-1:0]  data_par_i,
   input  logic              par_en_i,
   input  logic [2:0]        cpu_state_i,
   input  logic              probe_rdy_i,
   input  logic              backoff_i,
   input  logic              hold_ack_i,
   input  logic              init_i,
   input  logic              addr_hold_i,
   input  logic              mce_i,
   input  logic              bus_err_i,
   input  logic              rd_en_i,
   input  logic              rd_sel_i,
   output logic              par_err_o,
   output logic              mc_req_o,
   output logic [7:0]        mc_vector_o,
   output logic [63:0]       rd_data_o
);

   if (DATA_W % 8 != 0 || DATA_W == 0) begin : g_chk_data
      $error("DATA_W must be a non-zero multiple of 8");
   end
   if (ADDR_W == 0 || ADDR_W > CAP_W) begin : g_chk_addr
      $error("ADDR_W must be 1..64");
   end
   if (BEATS == 0) begin : g_chk_beats
      $error("BEATS must be at least 1");
   end
   if (TYP_LANE_LSB + LANES > CAP_W) begin : g_chk_lanes
      $error("lane mask does not fit the type register");
   end

   cyc_kind_t         kind_in;
   cyc_kind_t         cur_kind;
   logic              cur_active;
   logic              cur_elig;
   logic [ADDR_W-1:0] cur_addr;
   logic [LANES-1:0]  lane_err;
   logic [LANES-1:0]  lane_bad;
   logic              read_beat;
   logic              perr;
   logic              state_ok;
   logic              lines_ok;
   logic              en_counts;
   logic              log_err;
   logic              cap_valid;
   logic [CAP_W-1:0]  cap_addr;

   assign kind_in = '{lock: cyc_lock_i, mem: cyc_mem_i,
                      data: cyc_data_i, write: cyc_write_i};

   rpm_cycle_track #(.ADDR_W(ADDR_W), .BEATS(BEATS)) u_track (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .strobe_i    (addr_strobe_i),
      .addr_i      (addr_i),
      .kind_i      (kind_in),
      .burst_i     (burst_i),
      .addr_hold_i (addr_hold_i),
      .data_rdy_i  (data_rdy_i),
      .active_o    (cur_active),
      .elig_o      (cur_elig),
      .addr_o      (cur_addr),
      .kind_o      (cur_kind)
   );

   rpm_lane_parity #(.DATA_W(DATA_W)) u_par (
      .data_i     (data_i),
      .par_i      (data_par_i),
      .lane_err_o (lane_err)
   );

   assign read_beat = data_rdy_i && cur_active && !cur_kind.write;
   assign lane_bad  = lane_err & {LANES{read_beat}};
   assign perr      = |lane_bad;
   assign state_ok  = state_samples(cpu_state_i) || probe_rdy_i;
   assign lines_ok  = !backoff_i && !hold_ack_i && !init_i;
   assign en_counts = cur_elig && state_ok && lines_ok && par_en_i;
   assign log_err   = perr && en_counts;

   rpm_capture #(.ADDR_W(ADDR_W), .LANES(LANES)) u_cap (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .log_i     (log_err),
      .addr_i    (cur_addr),
      .kind_i    (cur_kind),
      .lanes_i   (lane_bad),
      .rd_en_i   (rd_en_i),
      .rd_sel_i  (rd_sel_i),
      .rd_data_o (rd_data_o),
      .valid_o   (cap_valid),
      .addr_q_o  (cap_addr)
   );

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         par_err_o <= 1'b0;
         mc_req_o  <= 1'b0;
      end else begin
         par_err_o <= perr;
         mc_req_o  <= mce_i && (log_err || bus_err_i);
      end
   end

   assign mc_vector_o = mc_req_o ? MC_VECTOR : 8'h00;

endmodule

// File: rtl/rpm_checker.sv
module rpm_checker (
   input logic        clk_i,
   input logic        rst_ni,
   input logic        data_rdy_i,
   input logic        mce_i,
   input logic        par_en_i,
   input logic        backoff_i,
   input logic        hold_ack_i,
   input logic        init_i,
   input logic        bus_err_i,
   input logic        rd_en_i,
   input logic        par_err_o,
   input logic        mc_req_o,
   input logic [7:0]  mc_vector_o,
   input logic        cap_valid,
   input logic [63:0] cap_addr
);

   logic seen;
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) seen <= 1'b0;
      else         seen <= 1'b1;
   end

   p_perr_after_beat_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (seen && par_err_o) |-> $past(data_rdy_i));

   p_log_needs_enable_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (seen && $rose(cap_valid)) |-> $past(par_en_i));

   p_lines_block_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (seen && $rose(cap_valid)) |-> (!$past(backoff_i) && !$past(hold_ack_i) && !$past(init_i)));

   p_req_needs_mce_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (seen && mc_req_o) |-> $past(mce_i));

   p_vector_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      mc_req_o |-> (mc_vector_o == 8'h12));

   p_bus_err_req_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (bus_err_i && mce_i) |=> mc_req_o);

   p_no_overwrite_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cap_valid && !rd_en_i) |=> $stable(cap_addr));

endmodule

bind rdpar_mc_capture rpm_checker u_chk (
   .clk_i       (clk_i),
   .rst_ni      (rst_ni),
   .data_rdy_i  (data_rdy_i),
   .mce_i       (mce_i),
   .par_en_i    (par_en_i),
   .backoff_i   (backoff_i),
   .hold_ack_i  (hold_ack_i),
   .init_i      (init_i),
   .bus_err_i   (bus_err_i),
   .rd_en_i     (rd_en_i),
   .par_err_o   (par_err_o),
   .mc_req_o    (mc_req_o),
   .mc_vector_o (mc_vector_o),
   .cap_valid   (cap_valid),
   .cap_addr    (cap_addr)
);

// File: tb/rdpar_mc_capture_tb_top.sv
module rdpar_mc_capture_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int AW = 16;
   localparam int DW = 16;
   localparam int NB = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic addr_strobe = 0, cyc_mem = 0, cyc_data = 0, cyc_write = 0, cyc_lock = 0, burst = 0;
   logic [AW-1:0] addr = '0;
   logic data_rdy = 0;
   logic [DW-1:0] data = '0;
   logic [1:0] data_par = '0;
   logic par_en = 0, probe_rdy = 0, backoff = 0, hold_ack = 0, init = 0, addr_hold = 0;
   logic [2:0] cpu_state = '0;
   logic mce = 0, bus_err = 0, rd_en = 0, rd_sel = 0;
   logic par_err, mc_req;
   logic [7:0] mc_vector;
   logic [63:0] rd_data;

   int n_chk = 0;
   int n_fail = 0;
   logic done = 1'b0;

   logic        exp_valid = 1'b0;
   logic [63:0] exp_addr = '0;
   logic [63:0] exp_type = '0;

   always #(CLK_PERIOD/2) clk = ~clk;

   rdpar_mc_capture #(.ADDR_W(AW), .DATA_W(DW), .BEATS(NB)) dut_i (
      .clk_i(clk), .rst_ni(rst_n), .addr_strobe_i(addr_strobe), .addr_i(addr),
      .cyc_mem_i(cyc_mem), .cyc_data_i(cyc_data), .cyc_write_i(cyc_write),
      .cyc_lock_i(cyc_lock), .burst_i(burst), .data_rdy_i(data_rdy), .data_i(data),
      .data_par_i(data_par), .par_en_i(par_en), .cpu_state_i(cpu_state),
      .probe_rdy_i(probe_rdy), .backoff_i(backoff), .hold_ack_i(hold_ack),
      .init_i(init), .addr_hold_i(addr_hold), .mce_i(mce), .bus_err_i(bus_err),
      .rd_en_i(rd_en), .rd_sel_i(rd_sel), .par_err_o(par_err), .mc_req_o(mc_req),
      .mc_vector_o(mc_vector), .rd_data_o(rd_data)
   );

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   function automatic logic [1:0] even_par(input logic [15:0] d);
      return {^d[15:8], ^d[7:0]};
   endfunction

   task automatic do_strobe(input logic [15:0] a, input logic mem, dc, wr, lk, bu,
                            input logic hold_start, input logic hold_after);
      @(negedge clk);
      addr = a; cyc_mem = mem; cyc_data = dc; cyc_write = wr; cyc_lock = lk;
      burst = bu; addr_hold = hold_start; addr_strobe = 1'b1;
      @(negedge clk);
      addr_strobe = 1'b0; addr_hold = hold_after;
   endtask

   task automatic do_beat(input logic [15:0] d, input logic [1:0] bad);
      @(negedge clk);
      data = d; data_par = even_par(d) ^ bad; data_rdy = 1'b1;
      @(negedge clk);
      data_rdy = 1'b0;
   endtask

   task automatic read_reg(input logic sel, output logic [63:0] v);
      @(negedge clk);
      rd_en = 1'b1; rd_sel = sel;
      @(negedge clk);
      rd_en = 1'b0;
      v = rd_data;
   endtask

   task automatic verify_regs(input string req);
      logic [63:0] v;
      read_reg(1'b1, v);
      chk(req, v, exp_type);
      read_reg(1'b0, v);
      chk(req, v, exp_addr);
      exp_valid = 1'b0;
      exp_type[0] = 1'b0;
   endtask

   task automatic model_log(input logic [15:0] a, input logic mem, dc, lk,
                            input logic [1:0] bad);
      if (!exp_valid) begin
         exp_valid = 1'b1;
         exp_addr = 64'(a);
         exp_type = (64'(bad) << 8) | (64'(lk) << 4) | (64'(mem) << 3) | (64'(dc) << 2) | 64'd1;
      end
   endtask

   task automatic scen(input string req, input logic [15:0] a, input logic mem, dc, wr, lk,
                       input logic [1:0] bad, input logic [2:0] st,
                       input logic pr, bo, ha, ini, pen, mc,
                       input logic hold_start, hold_beat, input logic [15:0] d);
      logic perr_e, log_e, req_e;
      do_strobe(a, mem, dc, wr, lk, 1'b0, hold_start, hold_beat);
      cpu_state = st; probe_rdy = pr; backoff = bo; hold_ack = ha; init = ini;
      par_en = pen; mce = mc;
      do_beat(d, bad);
      perr_e = !wr && (bad != 2'b00);
      log_e  = perr_e && !hold_start && (st <= 3'd1 || pr) && !bo && !ha && !ini && pen;
      req_e  = mc && log_e;
      chk({req, " par_err"}, 64'(par_err), 64'(perr_e));
      chk({req, " mc_req R8"}, 64'(mc_req), 64'(req_e));
      chk({req, " vector R8"}, 64'(mc_vector), req_e ? 64'h12 : 64'h0);
      if (log_e) model_log(a, mem, dc, lk, bad);
      cpu_state = '0; probe_rdy = 0; backoff = 0; hold_ack = 0; init = 0;
      par_en = 0; mce = 0; addr_hold = 0;
   endtask

   initial begin
      logic [63:0] v;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R13 reset state
      chk("R13 par_err", 64'(par_err), 64'h0);
      chk("R13 mc_req", 64'(mc_req), 64'h0);
      verify_regs("R13 regs");

      // R1 R2 R3 R5 R8 R11 sweep over state, probe, enable, mce, bad lanes
      for (int st = 0; st < 8; st++)
         for (int pr = 0; pr < 2; pr++)
            for (int pen = 0; pen < 2; pen++)
               for (int mc = 0; mc < 2; mc++)
                  for (int bad = 0; bad < 4; bad++) begin
                     scen("R1 R3 R5 sweep", 16'(st * 4099 + bad * 257 + pen * 31 + 7),
                          st[0], pr[0], 1'b0, mc[0], 2'(bad), 3'(st), pr[0],
                          1'b0, 1'b0, 1'b0, pen[0], mc[0], 1'b0, 1'b0,
                          16'(st * 911 + bad * 73 + mc * 5 + 3));
                     verify_regs("R2 R11 sweep regs");
                  end

      // R6 blocking lines, even with probe-ready
      for (int b = 1; b < 8; b++) begin
         scen("R6 lines", 16'h1234 + 16'(b), 1'b1, 1'b1, 1'b0, 1'b0, 2'b11, 3'd0, 1'b1,
              b[0], b[1], b[2], 1'b1, 1'b1, 1'b0, 1'b0, 16'h5a5a);
         verify_regs("R6 regs");
      end

      // R4 writes never checked
      scen("R4 write", 16'h0f0f, 1'b1, 1'b1, 1'b1, 1'b0, 2'b11, 3'd0, 1'b0,
           1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 16'h00ff);
      verify_regs("R4 regs");

      // R7 address hold
      scen("R7 started in hold", 16'h7001, 1'b1, 1'b1, 1'b0, 1'b0, 2'b01, 3'd0, 1'b0,
           1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 16'h1111);
      verify_regs("R7 regs none");
      scen("R7 hold after start", 16'h7002, 1'b0, 1'b0, 1'b0, 1'b1, 2'b10, 3'd1, 1'b0,
           1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 16'h2222);
      verify_regs("R7 regs logged");

      // R10 no overwrite while valid
      scen("R10 first", 16'hA001, 1'b1, 1'b1, 1'b0, 1'b0, 2'b01, 3'd0, 1'b0,
           1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 16'h0101);
      scen("R10 second", 16'hA002, 1'b0, 1'b0, 1'b0, 1'b1, 2'b10, 3'd0, 1'b0,
           1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 16'h0202);
      verify_regs("R10 kept first");
      verify_regs("R10 valid cleared");
      scen("R10 third", 16'hA003, 1'b1, 1'b0, 1'b0, 1'b1, 2'b11, 3'd0, 1'b0,
           1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 16'h0303);
      verify_regs("R10 overwritten");

      // R12 burst: two beats, error on the second, then a stray beat
      do_strobe(16'hB0B0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
      par_en = 1'b1; mce = 1'b1;
      do_beat(16'h1357, 2'b00);
      chk("R12 beat1", 64'(par_err), 64'h0);
      do_beat(16'h2468, 2'b10);
      chk("R12 beat2", 64'(par_err), 64'h1);
      chk("R12 beat2 req", 64'(mc_req), 64'h1);
      model_log(16'hB0B0, 1'b1, 1'b1, 1'b0, 2'b10);
      do_beat(16'h9999, 2'b11);
      chk("R12 stray beat", 64'(par_err), 64'h0);
      chk("R12 stray req", 64'(mc_req), 64'h0);
      par_en = 1'b0; mce = 1'b0;
      verify_regs("R12 regs");

      // R9 bus-check path
      @(negedge clk); bus_err = 1'b1; mce = 1'b1;
      @(negedge clk); bus_err = 1'b0; mce = 1'b0;
      chk("R9 req", 64'(mc_req), 64'h1);
      chk("R9 vector", 64'(mc_vector), 64'h12);
      @(negedge clk); bus_err = 1'b1;
      @(negedge clk); bus_err = 1'b0;
      chk("R9 masked", 64'(mc_req), 64'h0);
      verify_regs("R9 regs untouched");

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

endmodule